// File: doc/BRIEF.md
# Wavetable Voice Oscillator

This block is the oscillator of one synthesizer voice. A phase accumulator advances by a frequency word once for every sample it produces. The top bits of the accumulator pick one byte from a 256-entry table, and a host fills that table over a simple byte write port. The byte becomes a signed sample centred on zero. A mode input can select a 16-bit sample streamed in by the host in place of the table.

Two kinds of modulation use the other voices of the synthesizer, whose signals arrive on input ports. Phase modulation adds a scaled copy of another voice's output to the phase, but only for the current table lookup. The stored phase never takes in the offset. Ring modulation multiplies the sample by a chosen source signal and divides the product by 65535. One source code selects the voice's own unmodulated sample, so the voice can modulate itself.

Each result sits in an output register with a valid/ready handshake and feeds an envelope stage. While that stage holds the envelope at zero, the oscillator emits silence and its phase stays where it is.

Top module: `wt_voice`

## Requirements
- R1: After reset `o_valid` is 0 and both sample outputs are 0. The phase starts at 0, so the first sample taken with no hold and no modulation reads table entry 0.
- R2: In table mode (`stream_mode`=0) the sample is 256·T[i] − 32767. Here i is bits [ACC_W-1:ACC_W-8] of the phase, and T[i] is the byte stored at address i. Each accepted sample that is not held advances the phase by `freq`, modulo 2^ACC_W.
- R3: In streamed mode (`stream_mode`=1) the sample is S − 32767, where S is the last 16-bit value accepted on the stream input. `strm_ready` is always 1. S is 0x7FFF after reset. A value accepted on a clock edge is first used by the sample computed on the next edge.
- R4: With `pm_en`=1 and `pm_sel` below NSRC, the table index comes from (phase + sign-extended `pm_src[pm_sel]` shifted left by 18) modulo 2^ACC_W. A `pm_sel` of NSRC or more adds no offset.
- R5: The phase-modulation offset never enters the stored phase. The phase after any sample equals the sum of the frequency words alone.
- R6: With `ring_en`=1 and `ring_sel` below NSRC, `o_sample` = (raw × `ring_src[ring_sel]`) / 65535, truncated toward zero. `o_raw` always carries the unmodulated sample. With `ring_en`=0, `o_sample` equals `o_raw`.
- R7: A `ring_sel` of NSRC or more selects the voice's own raw sample (self-modulation), giving raw² / 65535.
- R8: While `env_hold`=1, an accepted sample is 0 on both outputs, and the phase does not advance.
- R9: While `o_valid`=1 and `o_ready`=0, the outputs stay stable and the phase does not advance. No sample is lost or skipped.
- R10: A table write lands on a clock edge. The sample computed on that same edge still reads the old byte; samples computed on later edges read the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table byte write strobe |
| tbl_addr | input | 8 | Table write address |
| tbl_data | input | 8 | Table write byte |
| freq | input | ACC_W | Phase increment per sample |
| stream_mode | input | 1 | 1 selects the streamed sample, 0 the table |
| strm_valid | input | 1 | Streamed sample valid |
| strm_ready | output | 1 | Streamed sample ready (always 1) |
| strm_data | input | 16 | Streamed sample, unsigned, offset by 0x7FFF |
| pm_en | input | 1 | Phase modulation enable |
| pm_sel | input | SEL_W | Phase modulation source code |
| pm_src | input | NSRC·17 | Other voices' outputs, 17-bit signed each, source k at bits [17k+16:17k] |
| ring_en | input | 1 | Ring modulation enable |
| ring_sel | input | SEL_W | Ring source code, NSRC or more selects self |
| ring_src | input | NSRC·17 | Other voices' raw samples, same packing as `pm_src` |
| env_hold | input | 1 | Envelope held at zero |
| o_valid | output | 1 | Output sample valid |
| o_ready | input | 1 | Downstream accepts the output sample |
| o_sample | output | 17 | Signed sample after ring modulation |
| o_raw | output | 17 | Signed sample before ring modulation |

## Verification
The block computes a new sample on a clock edge when its output register is empty or is being accepted. That sample appears on `o_sample` and `o_raw` right after that edge, so every result is due one clock after the inputs that produce it. The stored phase and table updates made on that same edge only affect the next sample. A table write or a streamed value accepted on edge k shows up first in the sample due after edge k+1. The bench's model follows the same order: it computes the expected sample from the pre-edge state, then applies phase, table and stream updates. It samples outputs one time unit after each rising edge, and while `o_ready` is low it expects the previous values unchanged.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int SMP_W  = 17;
  localparam int STRM_W = 16;
  localparam int TBL_AW = 8;
  localparam int TBL_DW = 8;
  localparam int PM_SH  = 18;
  localparam int DIV_K  = 16;
  localparam int PROD_W = 2 * SMP_W;
  localparam logic signed [SMP_W-1:0] MID = SMP_W'(32767);

  typedef logic signed [SMP_W-1:0] smp_t;

  // Truncating division by 2^DIV_K-1: shift estimate plus one correction step.
  function automatic smp_t ring_scale(input logic signed [PROD_W-1:0] p);
    logic [PROD_W-1:0] mag;
    logic [PROD_W-1:0] q;
    logic [PROD_W-1:0] rem;
    mag = p[PROD_W-1] ? $unsigned(-p) : $unsigned(p);
    q   = mag >> DIV_K;
    rem = mag - (q << DIV_K) + q;
    if (rem >= PROD_W'((64'd1 << DIV_K) - 64'd1)) q = q + PROD_W'(1);
    return p[PROD_W-1] ? -$signed(q[SMP_W-1:0]) : $signed(q[SMP_W-1:0]);
  endfunction
endpackage

// File: rtl/wt_table.sv
module wt_table #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wt_phase.sv
module wt_phase
  import wt_pkg::*;
#(
  parameter int ACC_W = 30,
  parameter int NSRC  = 7,
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  hold,
  input  logic [ACC_W-1:0]      freq,
  input  logic                  pm_en,
  input  logic [SEL_W-1:0]      pm_sel,
  input  logic [NSRC*SMP_W-1:0] pm_src,
  output logic [ACC_W-1:0]      acc_q,
  output logic [TBL_AW-1:0]     idx
);
  localparam int EXT_W = ACC_W + SMP_W;

  smp_t             mod_v;
  logic             mod_hit;
  logic [ACC_W-1:0] offset;
  logic [ACC_W-1:0] eff;

  always_comb begin
    mod_v   = '0;
    mod_hit = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (pm_sel == SEL_W'(k)) begin
        mod_v   = pm_src[k*SMP_W +: SMP_W];
        mod_hit = 1'b1;
      end
    end
  end

  always_comb begin
    offset = '0;
    if (pm_en && mod_hit)
      offset = ACC_W'({{ACC_W{mod_v[SMP_W-1]}}, mod_v} << PM_SH);
    eff = acc_q + offset;
  end

  assign idx = eff[ACC_W-1 -: TBL_AW];

  always_ff @(posedge clk) begin
    if (!rst_n)                acc_q <= '0;
    else if (step && !hold)    acc_q <= acc_q + freq;
  end

  logic unused_ext;
  assign unused_ext = (EXT_W == 0);
endmodule

// File: rtl/wt_shape.sv
module wt_shape
  import wt_pkg::*;
#(
  parameter int NSRC  = 7,
  parameter int SEL_W = 3
) (
  input  logic                  mode,
  input  logic                  hold,
  input  logic [TBL_DW-1:0]     tbl_byte,
  input  logic [STRM_W-1:0]     strm_val,
  input  logic                  ring_en,
  input  logic [SEL_W-1:0]      ring_sel,
  input  logic [NSRC*SMP_W-1:0] ring_src,
  output smp_t                  raw,
  output smp_t                  shaped
);
  smp_t                      src;
  logic signed [PROD_W-1:0]  prod;

  always_comb begin
    if (hold)
      raw = '0;
    else if (mode)
      raw = $signed({1'b0, strm_val}) - MID;
    else
      raw = $signed({1'b0, tbl_byte, {(STRM_W-TBL_DW){1'b0}}}) - MID;
  end

  always_comb begin
    src = raw;
    for (int k = 0; k < NSRC; k++) begin
      if (ring_sel == SEL_W'(k)) src = ring_src[k*SMP_W +: SMP_W];
    end
  end

  always_comb begin
    prod   = $signed({{SMP_W{raw[SMP_W-1]}}, raw}) * $signed({{SMP_W{src[SMP_W-1]}}, src});
    shaped = ring_en ? ring_scale(prod) : raw;
  end
endmodule

// File: rtl/wt_voice.sv
module wt_voice
  import wt_pkg::*;
#(
  parameter int ACC_W = 30,
  parameter int NSRC  = 7,
  parameter int SEL_W = $clog2(NSRC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tbl_we,
  input  logic [TBL_AW-1:0]     tbl_addr,
  input  logic [TBL_DW-1:0]     tbl_data,
  input  logic [ACC_W-1:0]      freq,
  input  logic                  stream_mode,
  input  logic                  strm_valid,
  output logic                  strm_ready,
  input  logic [STRM_W-1:0]     strm_data,
  input  logic                  pm_en,
  input  logic [SEL_W-1:0]      pm_sel,
  input  logic [NSRC*SMP_W-1:0] pm_src,
  input  logic                  ring_en,
  input  logic [SEL_W-1:0]      ring_sel,
  input  logic [NSRC*SMP_W-1:0] ring_src,
  input  logic                  env_hold,
  output logic                  o_valid,
  input  logic                  o_ready,
  output logic [SMP_W-1:0]      o_sample,
  output logic [SMP_W-1:0]      o_raw
);
  logic              step;
  logic [ACC_W-1:0]  acc_q;
  logic [TBL_AW-1:0] idx;
  logic [TBL_DW-1:0] tbl_byte;
  logic [STRM_W-1:0] strm_q;
  smp_t              raw_c;
  smp_t              shaped_c;

  assign step       = !o_valid || o_ready;
  assign strm_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)          strm_q <= STRM_W'(16'h7FFF);
    else if (strm_valid) strm_q <= strm_data;
  end

  wt_table #(.AW(TBL_AW), .DW(TBL_DW)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (idx),
    .rdata (tbl_byte)
  );

  wt_phase #(.ACC_W(ACC_W), .NSRC(NSRC), .SEL_W(SEL_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .hold   (env_hold),
    .freq   (freq),
    .pm_en  (pm_en),
    .pm_sel (pm_sel),
    .pm_src (pm_src),
    .acc_q  (acc_q),
    .idx    (idx)
  );

  wt_shape #(.NSRC(NSRC), .SEL_W(SEL_W)) u_shape (
    .mode     (stream_mode),
    .hold     (env_hold),
    .tbl_byte (tbl_byte),
    .strm_val (strm_q),
    .ring_en  (ring_en),
    .ring_sel (ring_sel),
    .ring_src (ring_src),
    .raw      (raw_c),
    .shaped   (shaped_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid  <= 1'b0;
      o_sample <= '0;
      o_raw    <= '0;
    end else if (step) begin
      o_valid  <= 1'b1;
      o_sample <= shaped_c;
      o_raw    <= raw_c;
    end
  end
endmodule

// File: rtl/wt_voice_chk.sv
module wt_voice_chk
  import wt_pkg::*;
#(
  parameter int ACC_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             env_hold,
  input logic             ring_en,
  input logic [ACC_W-1:0] freq,
  input logic [ACC_W-1:0] acc_q,
  input logic             o_valid,
  input logic             o_ready,
  input logic [SMP_W-1:0] o_sample,
  input logic [SMP_W-1:0] o_raw
);
  logic             take;
  logic [ACC_W-1:0] acc_nx;
  assign take   = !o_valid || o_ready;
  assign acc_nx = acc_q + freq;

  AST_STALL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_sample) && $stable(o_raw)); // R9
  AST_STALL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> $stable(acc_q)); // R9
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    take && env_hold |=> o_sample == '0 && o_raw == '0); // R8
  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    take && env_hold |=> $stable(acc_q)); // R8
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !env_hold |=> acc_q == $past(acc_nx)); // R2
  AST_DRY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !ring_en |=> o_sample == o_raw); // R6
endmodule

bind wt_voice wt_voice_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .env_hold (env_hold),
  .ring_en  (ring_en),
  .freq     (freq),
  .acc_q    (acc_q),
  .o_valid  (o_valid),
  .o_ready  (o_ready),
  .o_sample (o_sample),
  .o_raw    (o_raw)
);

// File: tb/wt_voice_bench.sv
module wt_voice_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 30;
  localparam int NS  = 7;
  localparam int SW  = 3;
  localparam int XW  = 17;
  localparam longint MASK = (64'sd1 <<< AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [7:0] tbl_addr = '0, tbl_data = '0;
  logic [AW-1:0] freq = '0;
  logic stream_mode = 1'b0, strm_valid = 1'b0, strm_ready;
  logic [15:0] strm_data = '0;
  logic pm_en = 1'b0, ring_en = 1'b0, env_hold = 1'b0, o_ready = 1'b1;
  logic [SW-1:0] pm_sel = '0, ring_sel = '0;
  logic [NS*XW-1:0] pm_src, ring_src;
  logic o_valid;
  logic [XW-1:0] o_sample, o_raw;

  int pm_v [NS];
  int rs_v [NS];
  int m_tbl [256];
  longint m_acc = 0;
  int m_strm = 32767, m_samp = 0, m_raw = 0;
  bit m_valid = 0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      pm_src[i*XW +: XW]   = XW'(pm_v[i]);
      ring_src[i*XW +: XW] = XW'(rs_v[i]);
    end
  end

  wt_voice u_wt_voice (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .freq(freq), .stream_mode(stream_mode), .strm_valid(strm_valid), .strm_ready(strm_ready),
    .strm_data(strm_data), .pm_en(pm_en), .pm_sel(pm_sel), .pm_src(pm_src),
    .ring_en(ring_en), .ring_sel(ring_sel), .ring_src(ring_src), .env_hold(env_hold),
    .o_valid(o_valid), .o_ready(o_ready), .o_sample(o_sample), .o_raw(o_raw)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd_smp();
    return int'($urandom_range(65535)) - 32767;
  endfunction

  // One clock: model the sample from pre-edge state, then apply edge updates.
  task automatic tick(input string req);
    bit stp = !m_valid || o_ready;
    longint eff;
    int idx, raw, src, smp;
    eff = m_acc;
    if (pm_en && pm_sel < NS) eff = (m_acc + (longint'(pm_v[pm_sel]) <<< 18)) & MASK;
    idx = int'(eff >> (AW - 8));
    if (env_hold) raw = 0;
    else if (stream_mode) raw = m_strm - 32767;
    else raw = m_tbl[idx] * 256 - 32767;
    src = (ring_sel < NS) ? rs_v[ring_sel] : raw;
    smp = ring_en ? int'((longint'(raw) * longint'(src)) / 65535) : raw;
    @(posedge clk);
    if (stp) begin
      m_valid = 1; m_samp = smp; m_raw = raw;
      if (!env_hold) m_acc = (m_acc + longint'(freq)) & MASK;
    end
    if (tbl_we) m_tbl[tbl_addr] = int'(tbl_data);
    if (strm_valid) m_strm = int'(strm_data);
    #1;
    chk(req, "o_valid", longint'(o_valid), longint'(m_valid));
    chk(req, "o_sample", longint'($signed(o_sample)), longint'(m_samp));
    chk(req, "o_raw", longint'($signed(o_raw)), longint'(m_raw));
  endtask

  task automatic rand_srcs();
    for (int i = 0; i < NS; i++) begin pm_v[i] = rnd_smp(); rs_v[i] = rnd_smp(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) m_tbl[i] = 0;
    for (int i = 0; i < NS; i++) begin pm_v[i] = 0; rs_v[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "o_valid in reset", longint'(o_valid), 0);
    chk("R1", "o_sample in reset", longint'(o_sample), 0);
    chk("R1", "o_raw in reset", longint'(o_raw), 0);
    rst_n = 1'b1;

    // Fill table while held: silence, phase parked.
    env_hold = 1'b1; freq = AW'(32'h0123_4567);
    for (int a = 0; a < 256; a++) begin
      tbl_we = 1'b1; tbl_addr = 8'(a); tbl_data = 8'($urandom);
      tick("R8");
    end
    tbl_we = 1'b0; env_hold = 1'b0; freq = '0;
    tick("R1");                                   // phase 0 reads entry 0
    tbl_we = 1'b1; tbl_addr = 8'd0; tbl_data = ~8'(m_tbl[0]);
    tick("R10");                                  // same edge: old byte
    tbl_we = 1'b0;
    tick("R10");                                  // next sample: new byte

    // Table mode, random frequencies.
    for (int b = 0; b < 5; b++) begin
      freq = AW'($urandom);
      for (int k = 0; k < 60; k++) tick("R2");
    end
    freq = '1;                                    // wraps every step
    for (int k = 0; k < 12; k++) tick("R2");

    // Streamed mode with extremes.
    stream_mode = 1'b1;
    strm_valid = 1'b1; strm_data = 16'h0000; tick("R3"); tick("R3");
    strm_data = 16'hFFFF; tick("R3"); tick("R3");
    chk("R3", "strm_ready", longint'(strm_ready), 1);
    for (int k = 0; k < 40; k++) begin
      strm_valid = 1'($urandom); strm_data = 16'($urandom);
      tick("R3");
    end
    strm_valid = 1'b0; stream_mode = 1'b0;

    // Phase modulation, including the no-offset code.
    pm_en = 1'b1; freq = AW'($urandom);
    for (int k = 0; k < 120; k++) begin
      rand_srcs(); pm_sel = SW'($urandom_range(7));
      tick("R4");
    end
    pm_en = 1'b0;
    for (int k = 0; k < 20; k++) tick("R5");

    // Ring modulation with external and self sources.
    ring_en = 1'b1;
    for (int k = 0; k < 120; k++) begin
      rand_srcs(); ring_sel = SW'($urandom_range(6));
      tick("R6");
    end
    ring_sel = 3'd7;
    for (int k = 0; k < 40; k++) tick("R7");
    stream_mode = 1'b1; strm_valid = 1'b1; strm_data = 16'h0000;
    tick("R7"); tick("R7");                       // (-32767)^2/65535 = 16383
    strm_data = 16'hFFFF; ring_sel = 3'd2; rs_v[2] = 32768;
    tick("R6"); tick("R6");                       // 32768*32768/65535 = 16384
    rs_v[2] = -32767; tick("R6");
    strm_valid = 1'b0; stream_mode = 1'b0; ring_en = 1'b0;

    // Back-pressure: nothing moves while stalled.
    for (int r = 0; r < 4; r++) begin
      o_ready = 1'b0;
      for (int k = 0; k < 5; k++) begin
        rand_srcs(); freq = AW'($urandom); ring_en = 1'($urandom); env_hold = 1'($urandom);
        tick("R9");
      end
      o_ready = 1'b1; env_hold = 1'b0;
      tick("R9"); tick("R9");
    end

    // Mixed random traffic with holds and table writes.
    for (int k = 0; k < 300; k++) begin
      rand_srcs();
      env_hold = ($urandom_range(5) == 0);
      o_ready = ($urandom_range(3) != 0);
      pm_en = 1'($urandom); pm_sel = SW'($urandom);
      ring_en = 1'($urandom); ring_sel = SW'($urandom);
      stream_mode = 1'($urandom); strm_valid = 1'($urandom); strm_data = 16'($urandom);
      tbl_we = 1'($urandom); tbl_addr = 8'($urandom); tbl_data = 8'($urandom);
      if ($urandom_range(15) == 0) freq = AW'($urandom);
      tick(env_hold ? "R8" : "R2");
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule